// File: doc/BRIEF.md
# Hashed Page Table Group Walker

This block searches a hashed page table in memory for the entry that translates one effective address. The caller has already found the segment that covers the address and presents the segment's virtual segment number, its size (256 MB or 1 TB), its large-page flag and base page size, together with the table register, the address and a flag saying whether the access is a store. The walker hashes the segment number with the page index, forms the address of a 128-byte group of eight two-doubleword entries, and reads the first doubleword of each slot over a 64-bit read port with a valid/ready request and a one-cycle response. Memory is big-endian, so each response is taken as the doubleword value itself.

A slot whose first doubleword, under a fixed mask, equals the expected tag has its second doubleword fetched as well. When large pages of several sizes are enabled, that doubleword must carry the size code of the segment's base page, or the slot is passed over. If no slot of the primary group hits, the walk repeats once in the group given by the inverted hash, now expecting the secondary-hash bit. The result reports hit or miss, the slot, which pass hit and both doublewords.

After a hit, a permission stage outside the block returns read and write grants. The walker then sets the referenced bit and, for a granted store, the changed bit, each through a single-byte write, so no other field of the entry is rewritten.

Top module: `hpt_group_walker`

## Requirements
- R1: The group address is (table register AND 0xFFFF_FFFF_FFFC_0000) OR (hash << 7), where the hash is first cut to its low 39 bits and then ANDed with (1 << (table register bits 4:0 + 11)) - 1.
- R2: The primary hash is the segment number XOR the page index; the page index is the address bits below 28 (256 MB segment) or below 40 (1 TB segment) shifted right by the page shift (12, 16 or 24 for size codes 0, 1, 2). For a 1 TB segment the segment number shifted left by 25 is XORed in as well. The secondary hash is the bitwise inverse of the primary one.
- R3: A slot's first doubleword hits when it equals the expected tag in bits 63:62 (segment size, 1 TB written as bit 62), 61:7 (abbreviated page number), bit 2 (large), bit 1 (secondary) and bit 0 (valid, always 1); all other bits are ignored.
- R4: The abbreviated page number is the page index ORed with the segment number shifted left by (segment shift - page shift), then shifted right by (16 - p) if the page shift p is below 16, else left by (p - 16).
- R5: Slots are searched from 0 to 7 in the primary group, then 0 to 7 in the secondary group with bit 1 expected set; the first hit ends the search.
- R6: With a large segment and multi-size mode on, a tag hit counts only if the second doubleword has bits 15:12 equal to 1 (size code 1) or bits 19:12 equal to 0 (size code 2); size code 0 never qualifies; a failing slot is skipped and the search continues.
- R7: A miss in both groups gives one result pulse with the hit flag low, after exactly sixteen tag reads.
- R8: Reads are 8-byte aligned: the first doubleword of slot s is at group + 16*s and its second at group + 16*s + 8; a request holds its address until accepted and never overlaps a byte write.
- R9: After a hit, if reading is granted and bit 8 of the second doubleword is clear, the walker writes one byte at entry offset 14 holding bits 15:8 of that doubleword with bit 0 set.
- R10: After a hit, on a store access with writing granted and bit 7 of the second doubleword clear, the walker writes one byte at entry offset 15 holding bits 7:0 with bit 7 set, after any offset-14 write.
- R11: No byte write occurs when the relevant bit is already set or the grant is absent; completion is signalled by one done pulse in every case, and the reported second doubleword then shows the bits that were set.
- R12: After reset the walker is ready for a request and no read, write, result or done pulse is active.
- R13: A hit reports the slot index, the pass that hit and both doublewords of the entry as they were read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, request accepted |
| req_ea | input | 64 | Effective address |
| req_write | input | 1 | Access is a store |
| tbl_reg | input | 64 | Table base (bits 63:18) and size code (bits 4:0) |
| seg_vsid | input | VSID_W | Virtual segment number |
| seg_1t | input | 1 | Segment is 1 TB |
| seg_large | input | 1 | Segment uses large pages |
| seg_psize | input | 2 | Base page size code: 0 = 4 KB, 1 = 64 KB, 2 = 16 MB |
| multi_psize | input | 1 | Multi-size large page mode |
| mem_rd_valid | output | 1 | Read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 64 | Read byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read doubleword |
| mem_wr_valid | output | 1 | Byte write request |
| mem_wr_ready | input | 1 | Byte write accepted |
| mem_wr_addr | output | 64 | Byte write address |
| mem_wr_byte | output | 8 | Byte write data |
| res_valid | output | 1 | Search result pulse |
| res_hit | output | 1 | Entry found |
| res_second | output | 1 | Hit came from the secondary group |
| res_slot | output | log2(N_SLOT) | Slot of the hit |
| res_dw0 | output | 64 | First doubleword of the hit |
| res_dw1 | output | 64 | Second doubleword of the hit |
| perm_valid | input | 1 | Grants present |
| perm_read | input | 1 | Read granted |
| perm_write | input | 1 | Write granted |
| upd_done | output | 1 | Update phase finished |

## Verification
On every cycle the assertions check the memory side: read alignment and held requests, no read beside a write, byte writes landing only on offsets 14 and 15 with the referenced or changed bit set in the data, and a reported hit carrying a valid bit and a secondary bit that matches the pass. The hash, group address, tag value, search order, size-code skipping and the choice of which bytes to write depend on arithmetic over the inputs and on table contents, so only the bench's sweeps over slots, passes, segment sizes, page sizes and grant combinations show them, by comparing addresses, read counts and written bytes with values worked out from the requirements.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

  localparam int DW = 64;

  localparam logic [63:0] BASE_KEEP = 64'hFFFF_FFFF_FFFC_0000;
  localparam logic [63:0] HASH_KEEP = 64'h0000_007F_FFFF_FFFF;

  localparam logic [63:0] F_SEG   = 64'hC000_0000_0000_0000;
  localparam logic [63:0] F_ONE_T = 64'h4000_0000_0000_0000;
  localparam logic [63:0] F_AVPN  = 64'h3FFF_FFFF_FFFF_FF80;
  localparam logic [63:0] F_LARGE = 64'h0000_0000_0000_0004;
  localparam logic [63:0] F_SEC   = 64'h0000_0000_0000_0002;
  localparam logic [63:0] F_VALID = 64'h0000_0000_0000_0001;
  localparam logic [63:0] TAG_MASK = F_SEG | F_AVPN | F_LARGE | F_SEC | F_VALID;

  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;

  localparam int ENTRY_BYTES = 16;
  localparam logic [63:0] OFF_DW1  = 64'd8;
  localparam logic [63:0] OFF_REFB = 64'd14;
  localparam logic [63:0] OFF_CHGB = 64'd15;

  typedef enum logic [3:0] {
    ST_IDLE, ST_R0, ST_W0, ST_R1, ST_W1, ST_PERM, ST_WRR, ST_WRC
  } walk_st_t;

  function automatic logic [6:0] pg_shift(input logic [1:0] code);
    case (code)
      2'd1:    pg_shift = 7'd16;
      2'd2:    pg_shift = 7'd24;
      default: pg_shift = 7'd12;
    endcase
  endfunction

endpackage

// File: rtl/hptw_locate.sv
module hptw_locate
  import hptw_pkg::*;
#(
  parameter int VSID_W = 37,
  parameter int N_SLOT = 8
) (
  input  logic [63:0]       tbl,
  input  logic [63:0]       ea,
  input  logic [VSID_W-1:0] vsid,
  input  logic              seg_1t,
  input  logic              seg_large,
  input  logic [1:0]        psize,
  input  logic              second,
  output logic [63:0]       grp_addr,
  output logic [63:0]       tag_val
);
  localparam int GRP_SHIFT = $clog2(N_SLOT * ENTRY_BYTES);

  logic [6:0]  sid_sh;
  logic [6:0]  p_sh;
  logic [63:0] vs;
  logic [63:0] seg_mask;
  logic [63:0] page_idx;
  logic [63:0] hash_raw;
  logic [63:0] hash_sel;
  logic [63:0] size_mask;
  logic [63:0] avpn_base;
  logic [63:0] avpn;

  always_comb begin
    sid_sh   = seg_1t ? 7'd40 : 7'd28;
    p_sh     = pg_shift(psize);
    vs       = 64'(vsid);
    seg_mask = (64'd1 << sid_sh) - 64'd1;
    page_idx = (ea & seg_mask) >> p_sh;
  end

  // hash form picked by segment size
  always_comb begin
    if (seg_1t) hash_raw = vs ^ (vs << 25) ^ page_idx;
    else        hash_raw = vs ^ page_idx;
    hash_sel  = second ? ~hash_raw : hash_raw;
    size_mask = (64'd1 << ({2'b00, tbl[4:0]} + 7'd11)) - 64'd1;
    grp_addr  = (tbl & BASE_KEEP) |
                ((hash_sel & HASH_KEEP & size_mask) << GRP_SHIFT);
  end

  always_comb begin
    avpn_base = page_idx | (vs << (sid_sh - p_sh));
    if (p_sh < 7'd16) avpn = avpn_base >> (7'd16 - p_sh);
    else              avpn = avpn_base << (p_sh - 7'd16);
    tag_val = (avpn & F_AVPN) | F_VALID |
              (seg_1t    ? F_ONE_T : 64'd0) |
              (seg_large ? F_LARGE : 64'd0) |
              (second    ? F_SEC   : 64'd0);
  end

endmodule

// File: rtl/hptw_entry_check.sv
module hptw_entry_check
  import hptw_pkg::*;
#(
  parameter bit SIZE_CHECK_EN = 1'b1
) (
  input  logic [63:0] dw0,
  input  logic [63:0] tag_val,
  input  logic [7:0]  size_fld,
  input  logic        seg_large,
  input  logic        multi,
  input  logic [1:0]  psize,
  output logic        tag_hit,
  output logic        size_ok
);
  assign tag_hit = ((dw0 & TAG_MASK) == tag_val);

  generate
    if (SIZE_CHECK_EN) begin : g_size
      logic code_ok;
      always_comb begin
        case (psize)
          2'd1:    code_ok = (size_fld[3:0] == 4'h1);
          2'd2:    code_ok = (size_fld == 8'h00);
          default: code_ok = 1'b0;
        endcase
      end
      assign size_ok = !(seg_large && multi) || code_ok;
    end else begin : g_nosize
      logic unused_ok;
      assign unused_ok = ^{size_fld, seg_large, multi, psize};
      assign size_ok   = 1'b1;
    end
  endgenerate

  always_comb begin
    if (tag_hit) assert_tag_valid_R3: assert (dw0[0]);
  end

endmodule

// File: rtl/hpt_group_walker.sv
module hpt_group_walker
  import hptw_pkg::*;
#(
  parameter int VSID_W        = 37,
  parameter int N_SLOT        = 8,
  parameter bit SIZE_CHECK_EN = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [63:0]                 req_ea,
  input  logic                        req_write,
  input  logic [63:0]                 tbl_reg,
  input  logic [VSID_W-1:0]           seg_vsid,
  input  logic                        seg_1t,
  input  logic                        seg_large,
  input  logic [1:0]                  seg_psize,
  input  logic                        multi_psize,
  output logic                        mem_rd_valid,
  input  logic                        mem_rd_ready,
  output logic [63:0]                 mem_rd_addr,
  input  logic                        mem_rsp_valid,
  input  logic [63:0]                 mem_rsp_data,
  output logic                        mem_wr_valid,
  input  logic                        mem_wr_ready,
  output logic [63:0]                 mem_wr_addr,
  output logic [7:0]                  mem_wr_byte,
  output logic                        res_valid,
  output logic                        res_hit,
  output logic                        res_second,
  output logic [$clog2(N_SLOT)-1:0]   res_slot,
  output logic [63:0]                 res_dw0,
  output logic [63:0]                 res_dw1,
  input  logic                        perm_valid,
  input  logic                        perm_read,
  input  logic                        perm_write,
  output logic                        upd_done
);
  localparam int SLOT_W = $clog2(N_SLOT);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOT - 1);

  walk_st_t          st;
  logic [SLOT_W-1:0] slot_q;
  logic              sec_q;
  logic [63:0]       ea_q;
  logic [63:0]       tbl_q;
  logic [VSID_W-1:0] vsid_q;
  logic              t_q, lg_q, multi_q, wr_q;
  logic [1:0]        ps_q;
  logic [63:0]       dw0_q;
  logic              need_chg_q;

  logic [63:0] grp_addr;
  logic [63:0] tag_val;
  logic        tag_hit;
  logic        size_ok;
  logic [63:0] entry_addr;
  logic        advance;

  hptw_locate #(.VSID_W(VSID_W), .N_SLOT(N_SLOT)) u_loc (
    .tbl(tbl_q), .ea(ea_q), .vsid(vsid_q), .seg_1t(t_q), .seg_large(lg_q),
    .psize(ps_q), .second(sec_q), .grp_addr(grp_addr), .tag_val(tag_val)
  );

  hptw_entry_check #(.SIZE_CHECK_EN(SIZE_CHECK_EN)) u_chk (
    .dw0(mem_rsp_data), .tag_val(tag_val), .size_fld(mem_rsp_data[19:12]),
    .seg_large(lg_q), .multi(multi_q), .psize(ps_q),
    .tag_hit(tag_hit), .size_ok(size_ok)
  );

  assign req_ready  = (st == ST_IDLE);
  assign entry_addr = grp_addr | (64'(slot_q) << $clog2(ENTRY_BYTES));
  assign advance    = mem_rsp_valid &&
                      (((st == ST_W0) && !tag_hit) || ((st == ST_W1) && !size_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      slot_q       <= '0;
      sec_q        <= 1'b0;
      ea_q         <= '0;
      tbl_q        <= '0;
      vsid_q       <= '0;
      t_q          <= 1'b0;
      lg_q         <= 1'b0;
      multi_q      <= 1'b0;
      wr_q         <= 1'b0;
      ps_q         <= '0;
      dw0_q        <= '0;
      need_chg_q   <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_byte  <= '0;
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      res_second   <= 1'b0;
      res_slot     <= '0;
      res_dw0      <= '0;
      res_dw1      <= '0;
      upd_done     <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      upd_done  <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          ea_q    <= req_ea;
          tbl_q   <= tbl_reg;
          vsid_q  <= seg_vsid;
          t_q     <= seg_1t;
          lg_q    <= seg_large;
          ps_q    <= seg_psize;
          multi_q <= multi_psize;
          wr_q    <= req_write;
          slot_q  <= '0;
          sec_q   <= 1'b0;
          st      <= ST_R0;
        end
        ST_R0: begin
          if (!mem_rd_valid) begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= entry_addr;
          end else if (mem_rd_ready) begin
            mem_rd_valid <= 1'b0;
            st           <= ST_W0;
          end
        end
        ST_W0: if (mem_rsp_valid) begin
          dw0_q <= mem_rsp_data;
          if (tag_hit) st <= ST_R1;
        end
        ST_R1: begin
          if (!mem_rd_valid) begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= entry_addr | OFF_DW1;
          end else if (mem_rd_ready) begin
            mem_rd_valid <= 1'b0;
            st           <= ST_W1;
          end
        end
        ST_W1: if (mem_rsp_valid && size_ok) begin
          res_valid  <= 1'b1;
          res_hit    <= 1'b1;
          res_slot   <= slot_q;
          res_second <= sec_q;
          res_dw0    <= dw0_q;
          res_dw1    <= mem_rsp_data;
          st         <= ST_PERM;
        end
        ST_PERM: if (perm_valid) begin
          need_chg_q <= wr_q && perm_write && !res_dw1[CHG_BIT];
          if (perm_read && !res_dw1[REF_BIT]) begin
            st <= ST_WRR;
          end else if (wr_q && perm_write && !res_dw1[CHG_BIT]) begin
            st <= ST_WRC;
          end else begin
            upd_done <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_WRR: begin
          if (!mem_wr_valid) begin
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= entry_addr + OFF_REFB;
            mem_wr_byte  <= res_dw1[15:8] | 8'h01;
          end else if (mem_wr_ready) begin
            mem_wr_valid      <= 1'b0;
            res_dw1[REF_BIT]  <= 1'b1;
            if (need_chg_q) begin
              st <= ST_WRC;
            end else begin
              upd_done <= 1'b1;
              st       <= ST_IDLE;
            end
          end
        end
        ST_WRC: begin
          if (!mem_wr_valid) begin
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= entry_addr + OFF_CHGB;
            mem_wr_byte  <= res_dw1[7:0] | 8'h80;
          end else if (mem_wr_ready) begin
            mem_wr_valid     <= 1'b0;
            res_dw1[CHG_BIT] <= 1'b1;
            upd_done         <= 1'b1;
            st               <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (advance) begin
        if (slot_q == LAST_SLOT) begin
          if (sec_q) begin
            res_valid  <= 1'b1;
            res_hit    <= 1'b0;
            res_second <= 1'b1;
            res_slot   <= '0;
            res_dw0    <= '0;
            res_dw1    <= '0;
            st         <= ST_IDLE;
          end else begin
            sec_q  <= 1'b1;
            slot_q <= '0;
            st     <= ST_R0;
          end
        end else begin
          slot_q <= slot_q + 1'b1;
          st     <= ST_R0;
        end
      end
    end
  end

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  assert_rd_align_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> mem_rd_addr[2:0] == 3'b000);
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !mem_wr_valid);
  assert_wr_offset_R9: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> mem_wr_addr[3:1] == 3'b111);
  assert_ref_byte_R9: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_addr[0] |-> mem_wr_byte[0]);
  assert_chg_byte_R10: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && mem_wr_addr[0] |-> mem_wr_byte[7]);
  assert_hit_tag_R13: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_hit |-> res_dw0[0] && (res_dw0[1] == res_second));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd_valid && !mem_wr_valid);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done);

endmodule

// File: tb/sim_hpt_group_walker.sv
module sim_hpt_group_walker;
  localparam int CLK_PERIOD = 10;
  localparam int VSID_W = 37;
  localparam logic [63:0] TBL0 = 64'h0000_0002_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic              req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [63:0]       req_ea = '0, tbl_reg = TBL0;
  logic [VSID_W-1:0] seg_vsid = '0;
  logic              seg_1t = 1'b0, seg_large = 1'b0, multi_psize = 1'b0;
  logic [1:0]        seg_psize = 2'd0;
  logic              mem_rd_valid, mem_rd_ready = 1'b0;
  logic [63:0]       mem_rd_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [63:0]       mem_rsp_data = '0;
  logic              mem_wr_valid, mem_wr_ready = 1'b0;
  logic [63:0]       mem_wr_addr;
  logic [7:0]        mem_wr_byte;
  logic              res_valid, res_hit, res_second;
  logic [2:0]        res_slot;
  logic [63:0]       res_dw0, res_dw1;
  logic              perm_valid = 1'b0, perm_read = 1'b0, perm_write = 1'b0;
  logic              upd_done;

  hpt_group_walker #(.VSID_W(VSID_W)) u0 (.*);

  int total = 0;
  int bad = 0;

  logic [63:0] mem [logic [63:0]];
  int          cyc = 0;
  int          rd_total = 0;
  int          wr_total = 0;
  logic [63:0] rd_log [0:63];
  logic [63:0] wr_alog [0:63];
  logic [7:0]  wr_blog [0:63];

  function automatic logic [63:0] mem_get(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    cyc          <= cyc + 1;
    mem_rd_ready <= (cyc % 3) != 0;
    mem_wr_ready <= (cyc % 2) == 0;
    mem_rsp_valid <= mem_rd_valid && mem_rd_ready;
    if (mem_rd_valid && mem_rd_ready) begin
      mem_rsp_data           <= mem_get(mem_rd_addr);
      rd_log[rd_total % 64]  <= mem_rd_addr;
      rd_total               <= rd_total + 1;
    end
    if (mem_wr_valid && mem_wr_ready) begin
      wr_alog[wr_total % 64] <= mem_wr_addr;
      wr_blog[wr_total % 64] <= mem_wr_byte;
      wr_total               <= wr_total + 1;
    end
  end

  // expected values from the requirement formulas
  function automatic int b_p(input logic [1:0] ps);
    return (ps == 2'd1) ? 16 : (ps == 2'd2) ? 24 : 12;
  endfunction
  function automatic logic [63:0] b_page(input logic [63:0] ea, input logic t, input logic [1:0] ps);
    int sid = t ? 40 : 28;
    return (ea & ((64'd1 << sid) - 64'd1)) >> b_p(ps);
  endfunction
  function automatic logic [63:0] b_grp(input logic [63:0] tbl, input logic [63:0] ea,
      input logic [VSID_W-1:0] v, input logic t, input logic [1:0] ps, input logic sec);
    logic [63:0] vs = 64'(v);
    logic [63:0] h = vs ^ b_page(ea, t, ps);
    if (t) h = h ^ (vs << 25);
    if (sec) h = ~h;
    h = h & ((64'd1 << 39) - 64'd1);
    h = h & ((64'd1 << (int'(tbl[4:0]) + 11)) - 64'd1);
    return (tbl & 64'hFFFF_FFFF_FFFC_0000) | (h << 7);
  endfunction
  function automatic logic [63:0] b_tag(input logic [63:0] ea, input logic [VSID_W-1:0] v,
      input logic t, input logic lg, input logic [1:0] ps, input logic sec);
    int p = b_p(ps);
    int sid = t ? 40 : 28;
    logic [63:0] a = b_page(ea, t, ps) | (64'(v) << (sid - p));
    if (p < 16) a = a >> (16 - p); else a = a << (p - 16);
    return (a & 64'h3FFF_FFFF_FFFF_FF80) | (t ? 64'h4000_0000_0000_0000 : 64'd0) |
           (lg ? 64'd4 : 64'd0) | (sec ? 64'd2 : 64'd0) | 64'd1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int          o_rd0;
  int          o_reads;
  logic        o_hit, o_sec;
  logic [2:0]  o_slot;
  logic [63:0] o_dw0, o_dw1;
  int          o_wr0;

  task automatic walk(input logic [63:0] ea, input logic [VSID_W-1:0] v, input logic t,
      input logic lg, input logic [1:0] ps, input logic mp, input logic wr);
    @(negedge clk);
    req_ea = ea; seg_vsid = v; seg_1t = t; seg_large = lg; seg_psize = ps;
    multi_psize = mp; req_write = wr; req_valid = 1'b1;
    o_rd0 = rd_total;
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    o_reads = rd_total - o_rd0;
    o_hit = res_hit; o_sec = res_second; o_slot = res_slot;
    o_dw0 = res_dw0; o_dw1 = res_dw1;
  endtask

  task automatic grant(input logic pr, input logic pw);
    o_wr0 = wr_total;
    perm_read = pr; perm_write = pw; perm_valid = 1'b1;
    @(negedge clk);
    perm_valid = 1'b0;
    while (!upd_done) @(negedge clk);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] ea, g, tg, g0, dw1;
    logic [VSID_W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk("R12 req_ready", 64'(req_ready), 64'd1);
    chk("R12 rd_valid", 64'(mem_rd_valid), 64'd0);
    chk("R12 wr_valid", 64'(mem_wr_valid), 64'd0);
    chk("R12 res_valid", 64'(res_valid), 64'd0);

    // R2 R3 R4 R5 R13 R11: sweep slots, passes and segment sizes
    for (int t = 0; t < 2; t++) begin
      for (int sec = 0; sec < 2; sec++) begin
        for (int s = 0; s < 8; s++) begin
          ea = 64'h0000_00AB_CDE0_0000 + 64'(s) * 64'h0000_0001_3579_B000 + 64'(t * 37 + sec) * 64'h0246_8000;
          v  = VSID_W'(37'h0_1234_5678 + 37'(s * 7 + t * 3 + sec));
          mem.delete();
          g  = b_grp(TBL0, ea, v, t[0], 2'd0, sec[0]);
          tg = b_tag(ea, v, t[0], 1'b0, 2'd0, sec[0]);
          if (sec == 1) begin
            g0 = b_grp(TBL0, ea, v, t[0], 2'd0, 1'b0);
            for (int k = 0; k < 8; k++) mem[g0 + 64'(16 * k)] = tg | 64'hF00_0000_0000_0078; // bit1 set: not a primary hit
          end
          if (s > 0) mem[g + 64'(16 * (s - 1))] = tg ^ 64'h400;
          dw1 = 64'h0000_0000_0ABC_D180 | (64'(s) << 20);
          mem[g + 64'(16 * s)]     = tg | 64'h38;
          mem[g + 64'(16 * s) + 8] = dw1;
          walk(ea, v, t[0], 1'b0, 2'd0, 1'b0, 1'b1);
          chk("R5 hit", 64'(o_hit), 64'd1);
          chk("R5 slot", 64'(o_slot), 64'(s));
          chk("R13 second", 64'(o_sec), 64'(sec));
          chk("R13 dw0", o_dw0, tg | 64'h38);
          chk("R13 dw1", o_dw1, dw1);
          chk("R5 read count", 64'(o_reads), 64'(sec ? s + 10 : s + 2));
          chk("R2 first read addr", rd_log[o_rd0 % 64], b_grp(TBL0, ea, v, t[0], 2'd0, 1'b0));
          chk("R8 dw1 addr", rd_log[(o_rd0 + o_reads - 1) % 64], g + 64'(16 * s) + 8);
          grant(1'b1, 1'b1);
          chk("R11 no write when set", 64'(wr_total - o_wr0), 64'd0);
        end
      end
    end

    // R7 R1: miss with several table sizes
    for (int z = 0; z < 3; z++) begin
      logic [63:0] tb;
      tb = TBL0 | 64'(z * 3);
      tbl_reg = tb;
      mem.delete();
      ea = 64'h0000_0000_0FED_C000 + 64'(z) * 64'h1111_1000;
      v  = VSID_W'(37'h1F_0F0F_0F0F + 37'(z));
      walk(ea, v, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
      chk("R7 miss", 64'(o_hit), 64'd0);
      chk("R7 reads", 64'(o_reads), 64'd16);
      chk("R1 primary group", rd_log[o_rd0 % 64], b_grp(tb, ea, v, 1'b0, 2'd0, 1'b0));
      chk("R1 secondary group", rd_log[(o_rd0 + 8) % 64], b_grp(tb, ea, v, 1'b0, 2'd0, 1'b1));
      chk("R8 last slot addr", rd_log[(o_rd0 + 15) % 64], b_grp(tb, ea, v, 1'b0, 2'd0, 1'b1) + 64'd112);
    end
    tbl_reg = TBL0;

    // R6: size-code checks in multi-size mode
    for (int ps = 0; ps < 3; ps++) begin
      ea = 64'h0000_0000_0A5A_0000;
      v  = VSID_W'(37'h0_0777_1234);
      mem.delete();
      g  = b_grp(TBL0, ea, v, 1'b0, 2'(ps), 1'b0);
      tg = b_tag(ea, v, 1'b0, 1'b1, 2'(ps), 1'b0);
      mem[g]      = tg;
      mem[g + 8]  = (ps == 1) ? 64'h2180 : 64'h1_0180;
      mem[g + 16] = tg;
      mem[g + 24] = (ps == 1) ? 64'h1180 : 64'h100_0180;
      walk(ea, v, 1'b0, 1'b1, 2'(ps), 1'b1, 1'b0);
      if (ps == 0) begin
        chk("R6 base 4K never qualifies", 64'(o_hit), 64'd0);
        chk("R6 reads", 64'(o_reads), 64'd18);
      end else begin
        chk("R6 skip bad code", 64'(o_hit), 64'd1);
        chk("R6 slot", 64'(o_slot), 64'd1);
        chk("R6 reads", 64'(o_reads), 64'd4);
        chk("R4 large tag", o_dw0, tg);
        grant(1'b1, 1'b0);
      end
      walk(ea, v, 1'b0, 1'b1, 2'(ps), 1'b0, 1'b0);
      chk("R6 mode off takes slot 0", 64'(o_slot), 64'd0);
      chk("R6 mode off hit", 64'(o_hit), 64'd1);
      grant(1'b1, 1'b0);
    end

    // R9 R10 R11: referenced/changed byte writes
    for (int c = 0; c < 5; c++) begin
      logic wr, pr, pw;
      logic [63:0] d1;
      wr = (c == 1) || (c == 2) || (c == 3);
      pr = (c != 3);
      pw = (c != 0) && (c != 3);
      d1 = (c == 2 || c == 4) ? 64'h1234_5112 : 64'h1234_5012;
      ea = 64'h0000_0000_3210_0000 + 64'(c) * 64'h1000;
      v  = VSID_W'(37'h0_0ABC_0000 + 37'(c));
      mem.delete();
      g  = b_grp(TBL0, ea, v, 1'b0, 2'd0, 1'b0);
      tg = b_tag(ea, v, 1'b0, 1'b0, 2'd0, 1'b0);
      mem[g + 48] = tg;
      mem[g + 56] = d1;
      walk(ea, v, 1'b0, 1'b0, 2'd0, 1'b0, wr);
      chk("R13 slot 3", 64'(o_slot), 64'd3);
      grant(pr, pw);
      case (c)
        0: begin
          chk("R9 one write", 64'(wr_total - o_wr0), 64'd1);
          chk("R9 addr", wr_alog[o_wr0 % 64], g + 48 + 14);
          chk("R9 byte", 64'(wr_blog[o_wr0 % 64]), 64'h51);
          chk("R11 dw1 shows ref", res_dw1, 64'h1234_5112);
        end
        1: begin
          chk("R10 two writes", 64'(wr_total - o_wr0), 64'd2);
          chk("R9 addr first", wr_alog[o_wr0 % 64], g + 48 + 14);
          chk("R10 addr", wr_alog[(o_wr0 + 1) % 64], g + 48 + 15);
          chk("R10 byte", 64'(wr_blog[(o_wr0 + 1) % 64]), 64'h92);
          chk("R11 dw1 shows both", res_dw1, 64'h1234_5192);
        end
        2: begin
          chk("R10 only change write", 64'(wr_total - o_wr0), 64'd1);
          chk("R10 addr", wr_alog[o_wr0 % 64], g + 48 + 15);
          chk("R10 byte", 64'(wr_blog[o_wr0 % 64]), 64'h92);
        end
        default: begin
          chk("R11 no grant no write", 64'(wr_total - o_wr0), 64'd0);
          chk("R11 dw1 unchanged", res_dw1, d1);
        end
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule